// File: doc/BRIEF.md
# Dual-Pointer Stepping Video Memory Window

This block sits between a byte-wide CPU register interface and a 17-bit video memory. The CPU sees six byte registers: three that expose an address pointer, two data ports and a control byte. Inside, the block keeps two independent pointers. Each pointer has a step code and a direction flag. The step sizes include powers of two and a set of screen-row strides (40, 80, 160, 320, 640). Software can therefore walk a pixel column or a text column with one register access per element.

Each data port is tied to its own pointer. An access through a data port performs one memory transaction at that pointer's address. The pointer then advances by its step, up or down. A select bit in the control byte decides which of the two pointers the three address registers show. It has no effect on which pointer a data port uses. The memory side uses a request/acknowledge handshake of any latency. While a transaction is in flight, the CPU side reports itself not ready.

Top module: `vram_window`

## Requirements
- R1: Register offsets are 0 = address low byte, 1 = address middle byte, 2 = address high byte, 3 = data port 0, 4 = data port 1 and 5 = control. The high byte holds the step code in bits 7:4, the decrement flag in bit 3, zeros in bits 2:1 and address bit 16 in bit 0. A register read returns the current value with `cpu_rvalid` one cycle after acceptance.
- R2: Control bit 0 is the select bit. When it is 0, offsets 0..2 read and write pointer 0. When it is 1, they read and write pointer 1. Reading control returns the select in bit 0 and zeros in bits 7:1.
- R3: Data port 0 always accesses memory at pointer 0 and data port 1 at pointer 1, whatever the select bit holds.
- R4: Step codes 1 to 10 move a pointer by 1, 2, 4, 8, 16, 32, 64, 128, 256 and 512 after each data-port access.
- R5: Step codes 11 to 15 move a pointer by 40, 80, 160, 320 and 640 after each data-port access.
- R6: Step code 0 leaves the pointer unchanged after a data-port access.
- R7: When the decrement flag is 1, the pointer moves down by the step instead of up.
- R8: Pointer arithmetic wraps modulo 2^17 in both directions.
- R9: `mem_req` stays high, with a stable address and direction, until `mem_ack`. `cpu_ready` is low while a transaction is in flight.
- R10: A data-port read returns `mem_rdata` with `cpu_rvalid` in the cycle after `mem_ack`. A data-port write never raises `cpu_rvalid`.
- R11: After reset, both pointers, their step codes, their decrement flags and the select bit read as zero.
- R12: Writes to offsets 6 and 7 change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_valid | input | 1 | CPU access strobe, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_reg | input | 3 | Register offset |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_ready | output | 1 | Block can accept an access |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cpu_rdata | output | 8 | Read data |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_ack` |
| mem_ack | input | 1 | Memory transaction completion |

## Verification
On every cycle, the assertions check the memory handshake: the request is held with a stable address until acknowledged, and the CPU side is busy during it. They also check that a read completion produces a read-valid pulse, that a write completion does not, and that a pointer with step code 0 keeps its address across a completed access. The step table, the decrement direction, wrap-around at both ends of the 17-bit space, and the independence of the data ports from the select bit can be shown only by the bench's scenarios. In those scenarios, pointers are walked through every step code in both directions, and the memory addresses and register readback are compared against a model.

// File: rtl/vwin_pkg.sv
package vwin_pkg;

  localparam int BYTE_W  = 8;
  localparam int CODE_W  = 4;
  localparam int STEP_W  = 10;
  localparam int NUM_PTR = 2;

  localparam logic [2:0] OFF_LO    = 3'd0;
  localparam logic [2:0] OFF_MID   = 3'd1;
  localparam logic [2:0] OFF_HI    = 3'd2;
  localparam logic [2:0] OFF_PORT0 = 3'd3;
  localparam logic [2:0] OFF_PORT1 = 3'd4;
  localparam logic [2:0] OFF_CTRL  = 3'd5;

  typedef enum logic {ST_IDLE, ST_BUSY} seq_state_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              dec;
  } ptr_mode_t;

  // Step size for a code: 0 -> none, 1..10 -> powers of two, 11..15 -> row strides
  function automatic logic [STEP_W-1:0] step_amount(input logic [CODE_W-1:0] code);
    logic [STEP_W-1:0] s;
    if (code == '0)
      s = '0;
    else if (code <= 4'd10)
      s = STEP_W'(1) << (code - 4'd1);
    else
      s = STEP_W'(40) << (code - 4'd11);
    return s;
  endfunction

endpackage

// File: rtl/vwin_rst_sync.sv
module vwin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/vwin_stepper.sv
module vwin_stepper
  import vwin_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  ptr_mode_t         mode,
  output logic [ADDR_W-1:0] nxt_addr
);
  logic [ADDR_W-1:0] delta;

  always_comb begin
    delta = ADDR_W'(step_amount(mode.code));
    if (mode.dec)
      nxt_addr = cur_addr - delta;
    else
      nxt_addr = cur_addr + delta;
  end
endmodule

// File: rtl/vwin_pointer.sv
module vwin_pointer
  import vwin_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_mid,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output ptr_mode_t         mode
);
  localparam int HI_BITS = ADDR_W - 16;

  logic [ADDR_W-1:0] addr_q, addr_d, stepped;
  ptr_mode_t         mode_q, mode_d;
  logic              upd_en;
  logic              unused_hi;

  assign unused_hi = ^wdata[2:0];

  vwin_stepper #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr (addr_q),
    .mode     (mode_q),
    .nxt_addr (stepped)
  );

  assign upd_en = wr_lo | wr_mid | wr_hi | advance;

  always_comb begin
    addr_d = addr_q;
    mode_d = mode_q;
    if (advance) begin
      addr_d = stepped;
    end else begin
      if (wr_lo)  addr_d[7:0]  = wdata;
      if (wr_mid) addr_d[15:8] = wdata;
      if (wr_hi) begin
        addr_d[ADDR_W-1:16] = wdata[HI_BITS-1:0];
        mode_d.code         = wdata[7:4];
        mode_d.dec          = wdata[3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      mode_q <= mode_d;
    end
  end

  assign addr = addr_q;
  assign mode = mode_q;
endmodule

// File: rtl/vwin_seq.sv
module vwin_seq
  import vwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_port,
  input  logic              start_we,
  input  logic [BYTE_W-1:0] start_wdata,
  input  logic              mem_ack,
  output logic              busy,
  output logic              act_port,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              done,
  output logic              rd_done
);
  seq_state_e        state_q, state_d;
  logic              port_q, we_q;
  logic [BYTE_W-1:0] wdata_q;
  logic              cap_en;

  assign cap_en = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start)   state_d = ST_BUSY;
      ST_BUSY: if (mem_ack) state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q  <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (cap_en) begin
      port_q  <= start_port;
      we_q    <= start_we;
      wdata_q <= start_wdata;
    end
  end

  assign busy      = (state_q == ST_BUSY);
  assign mem_req   = busy;
  assign mem_we    = we_q;
  assign mem_wdata = wdata_q;
  assign act_port  = port_q;
  assign done      = busy & mem_ack;
  assign rd_done   = done & ~we_q;
endmodule

// File: rtl/vram_window.sv
module vram_window
  import vwin_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [2:0]        cpu_reg,
  input  logic [7:0]        cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [7:0]        cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack
);
  localparam int HI_BITS = ADDR_W - 16;

  logic rst_sync_n;
  logic accept, is_data, seq_busy, act_port, seq_done, seq_rd_done;
  logic sel_q, sel_d, sel_en;
  logic [NUM_PTR-1:0]             wr_lo, wr_mid, wr_hi, adv;
  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_addr_all;
  logic [NUM_PTR-1:0][CODE_W-1:0] ptr_code_all;
  ptr_mode_t                      ptr_mode [NUM_PTR];
  logic [BYTE_W-1:0] hi_view, reg_view, rdata_d;
  logic              rvalid_d;

  vwin_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign cpu_ready = ~seq_busy;
  assign accept    = cpu_valid & cpu_ready;
  assign is_data   = (cpu_reg == OFF_PORT0) | (cpu_reg == OFF_PORT1);

  // Select bit
  assign sel_en = accept & cpu_we & (cpu_reg == OFF_CTRL);
  assign sel_d  = cpu_wdata[0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  sel_q <= 1'b0;
    else if (sel_en)  sel_q <= sel_d;
  end

  // Pointer bank
  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    assign wr_lo[i]  = accept & cpu_we & (cpu_reg == OFF_LO)  & (sel_q == 1'(i));
    assign wr_mid[i] = accept & cpu_we & (cpu_reg == OFF_MID) & (sel_q == 1'(i));
    assign wr_hi[i]  = accept & cpu_we & (cpu_reg == OFF_HI)  & (sel_q == 1'(i));
    assign adv[i]    = seq_done & (act_port == 1'(i));

    vwin_pointer #(.ADDR_W(ADDR_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_lo   (wr_lo[i]),
      .wr_mid  (wr_mid[i]),
      .wr_hi   (wr_hi[i]),
      .wdata   (cpu_wdata),
      .advance (adv[i]),
      .addr    (ptr_addr_all[i]),
      .mode    (ptr_mode[i])
    );
    assign ptr_code_all[i] = ptr_mode[i].code;
  end

  // Memory sequencer
  vwin_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (accept & is_data),
    .start_port  (cpu_reg == OFF_PORT1),
    .start_we    (cpu_we),
    .start_wdata (cpu_wdata),
    .mem_ack     (mem_ack),
    .busy        (seq_busy),
    .act_port    (act_port),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .done        (seq_done),
    .rd_done     (seq_rd_done)
  );

  assign mem_addr = ptr_addr_all[act_port];

  // Register readback
  always_comb begin
    hi_view                = '0;
    hi_view[7:4]           = ptr_mode[sel_q].code;
    hi_view[3]             = ptr_mode[sel_q].dec;
    hi_view[HI_BITS-1:0]   = ptr_addr_all[sel_q][ADDR_W-1:16];
    case (cpu_reg)
      OFF_LO:   reg_view = ptr_addr_all[sel_q][7:0];
      OFF_MID:  reg_view = ptr_addr_all[sel_q][15:8];
      OFF_HI:   reg_view = hi_view;
      OFF_CTRL: reg_view = {7'd0, sel_q};
      default:  reg_view = '0;
    endcase
  end

  assign rvalid_d = (accept & ~cpu_we & ~is_data) | seq_rd_done;
  assign rdata_d  = seq_rd_done ? mem_rdata : reg_view;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cpu_rvalid <= 1'b0;
    else             cpu_rvalid <= rvalid_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   cpu_rdata <= '0;
    else if (rvalid_d) cpu_rdata <= rdata_d;
  end
endmodule

// File: rtl/vwin_checker.sv
module vwin_checker #(
  parameter int ADDR_W = 17
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cpu_ready,
  input logic                  cpu_rvalid,
  input logic                  mem_req,
  input logic                  mem_ack,
  input logic                  mem_we,
  input logic [ADDR_W-1:0]     mem_addr,
  input logic                  act_port,
  input logic [1:0][ADDR_W-1:0] ptr_addr_all,
  input logic [1:0][3:0]       ptr_code_all
);
  // R9: request held with stable address and direction until acknowledged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9: CPU side busy during a transaction
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  // R10: read completion yields read-valid next cycle
  p_rdret_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we) |=> cpu_rvalid);

  // R10: write completion yields no read-valid
  p_wr_norv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_we) |=> !cpu_rvalid);

  // R6: step code zero keeps the pointer in place
  p_zero_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && ptr_code_all[act_port] == 4'd0) |=> $stable(ptr_addr_all[act_port]));
endmodule

bind vram_window vwin_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .cpu_ready    (cpu_ready),
  .cpu_rvalid   (cpu_rvalid),
  .mem_req      (mem_req),
  .mem_ack      (mem_ack),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .act_port     (act_port),
  .ptr_addr_all (ptr_addr_all),
  .ptr_code_all (ptr_code_all)
);

// File: tb/sim_vram_window.sv
module sim_vram_window;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_valid, cpu_we;
  logic [2:0]  cpu_reg;
  logic [7:0]  cpu_wdata;
  logic        cpu_ready, cpu_rvalid;
  logic [7:0]  cpu_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0]  ram    [int];
  logic [7:0]  shadow [int];
  logic [16:0] last_addr;
  logic [16:0] pa [2];
  logic [3:0]  pc [2];
  logic        pd [2];
  logic        sel_m;

  vram_window u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_reg(cpu_reg), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model: random acknowledge latency
  always @(negedge clk) begin
    if (mem_req) begin
      mem_ack   = ($urandom % 3) != 0;
      mem_rdata = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
    end else begin
      mem_ack   = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      last_addr = mem_addr;
      if (mem_we) ram[int'(mem_addr)] = mem_wdata;
    end
  end

  function automatic logic [9:0] step_of(input logic [3:0] c);
    case (c)
      4'd0: return 10'd0;     4'd1: return 10'd1;     4'd2: return 10'd2;
      4'd3: return 10'd4;     4'd4: return 10'd8;     4'd5: return 10'd16;
      4'd6: return 10'd32;    4'd7: return 10'd64;    4'd8: return 10'd128;
      4'd9: return 10'd256;   4'd10: return 10'd512;  4'd11: return 10'd40;
      4'd12: return 10'd80;   4'd13: return 10'd160;  4'd14: return 10'd320;
      default: return 10'd640;
    endcase
  endfunction

  function automatic logic [16:0] moved(input logic [16:0] a, input logic [3:0] c, input logic d);
    int v;
    v = d ? (int'(a) - int'(step_of(c))) : (int'(a) + int'(step_of(c)));
    return 17'(v & 32'h1FFFF);
  endfunction

  function automatic logic [7:0] view(input logic [2:0] off);
    int s;
    s = int'(sel_m);
    case (off)
      3'd0: return pa[s][7:0];
      3'd1: return pa[s][15:8];
      3'd2: return {pc[s], pd[s], 2'b00, pa[s][16]};
      3'd5: return {7'd0, sel_m};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic [2:0] off, input logic we, input logic [7:0] wd,
                        output logic [7:0] rd, output bit rv_seen, output bit busy_seen);
    int guard;
    @(negedge clk);
    guard = 0;
    while (!cpu_ready && guard < 1000) begin @(negedge clk); guard++; end
    cpu_valid = 1'b1; cpu_we = we; cpu_reg = off; cpu_wdata = wd;
    @(negedge clk);
    cpu_valid = 1'b0; cpu_we = 1'b0;
    busy_seen = !cpu_ready;
    rv_seen = 1'b0;
    rd = 8'hxx;
    guard = 0;
    if (!we) begin
      while (!cpu_rvalid && guard < 1000) begin @(negedge clk); guard++; end
      rd = cpu_rdata;
    end else begin
      while (!cpu_ready && guard < 1000) begin
        if (cpu_rvalid) rv_seen = 1'b1;
        @(negedge clk); guard++;
      end
      if (cpu_rvalid) rv_seen = 1'b1;
    end
  endtask

  task automatic write_reg(input logic [2:0] off, input logic [7:0] v);
    logic [7:0] rd; bit rv, bz;
    int s;
    s = int'(sel_m);
    bus_op(off, 1'b1, v, rd, rv, bz);
    case (off)
      3'd0: pa[s][7:0]  = v;
      3'd1: pa[s][15:8] = v;
      3'd2: begin pc[s] = v[7:4]; pd[s] = v[3]; pa[s][16] = v[0]; end
      3'd5: sel_m = v[0];
      default: ;
    endcase
  endtask

  task automatic read_check(input logic [2:0] off, input string req);
    logic [7:0] rd, ex; bit rv, bz;
    ex = view(off);
    bus_op(off, 1'b0, 8'h00, rd, rv, bz);
    check(rd === ex, req, 32'(rd), 32'(ex));
  endtask

  task automatic verify_regs(input string req);
    read_check(3'd0, req);
    read_check(3'd1, req);
    read_check(3'd2, req);
  endtask

  task automatic data_op(input int p, input logic we, input logic [7:0] wd);
    logic [16:0] ea; logic [7:0] rd, ex; bit rv, bz;
    ea = pa[p];
    bus_op(p == 1 ? 3'd4 : 3'd3, we, wd, rd, rv, bz);
    check(last_addr == ea, "R3", 32'(last_addr), 32'(ea));
    check(bz, "R9", 32'(bz), 32'd1);
    if (we) begin
      shadow[int'(ea)] = wd;
      check(!rv, "R10", 32'(rv), 32'd0);
    end else begin
      ex = shadow.exists(int'(ea)) ? shadow[int'(ea)] : 8'h00;
      check(rd === ex, "R10", 32'(rd), 32'(ex));
    end
    pa[p] = moved(pa[p], pc[p], pd[p]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    cpu_valid = 0; cpu_we = 0; cpu_reg = 0; cpu_wdata = 0;
    mem_ack = 0; mem_rdata = 0; last_addr = '0;
    for (int i = 0; i < 2; i++) begin pa[i] = '0; pc[i] = '0; pd[i] = 0; end
    sel_m = 0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R11: reset state of both pointers and select
    verify_regs("R11");
    read_check(3'd5, "R11");
    write_reg(3'd5, 8'h01);
    verify_regs("R11");
    write_reg(3'd5, 8'h00);

    // R1/R2: pointers are separately addressed through select
    write_reg(3'd0, 8'h11); write_reg(3'd1, 8'h22); write_reg(3'd2, 8'h5B);
    write_reg(3'd5, 8'hFF);
    read_check(3'd5, "R2");
    write_reg(3'd0, 8'h99); write_reg(3'd1, 8'h88); write_reg(3'd2, 8'hE6);
    verify_regs("R2");
    write_reg(3'd5, 8'h00);
    verify_regs("R1");

    // R3: ports follow their own pointer whatever the select holds
    write_reg(3'd5, 8'h01);
    data_op(0, 1'b1, 8'hA5);
    data_op(1, 1'b1, 8'h5A);
    write_reg(3'd5, 8'h00);
    data_op(1, 1'b1, 8'h3C);
    verify_regs("R3");

    // R4/R5/R6/R7: every step code, both directions
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 16; c++) begin
        write_reg(3'd0, 8'h34); write_reg(3'd1, 8'h12);
        write_reg(3'd2, {4'(c), 1'(d), 3'b001});
        data_op(0, 1'b1, 8'(c + 16 * d));
        if (d == 1)       verify_regs("R7");
        else if (c == 0)  verify_regs("R6");
        else if (c <= 10) verify_regs("R4");
        else              verify_regs("R5");
      end
    end

    // R8: wrap at the top and at the bottom
    write_reg(3'd0, 8'hFF); write_reg(3'd1, 8'hFF); write_reg(3'd2, 8'h11);
    data_op(0, 1'b0, 8'h00);
    verify_regs("R8");
    write_reg(3'd0, 8'h00); write_reg(3'd1, 8'h00); write_reg(3'd2, 8'hF8);
    data_op(0, 1'b1, 8'h77);
    verify_regs("R8");
    data_op(0, 1'b0, 8'h00);

    // R12: unused offsets
    write_reg(3'd6, 8'hFF);
    write_reg(3'd7, 8'hFF);
    read_check(3'd6, "R12");
    read_check(3'd7, "R12");
    verify_regs("R12");
    read_check(3'd5, "R12");

    // Random mix
    for (int n = 0; n < 500; n++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 2)       write_reg(3'($urandom % 3), 8'($urandom));
      else if (r == 2) write_reg(3'd5, 8'($urandom));
      else if (r == 3) read_check(3'($urandom % 3), "R1");
      else if (r == 9) read_check(3'd5, "R2");
      else             data_op(int'($urandom % 2), 1'($urandom), 8'($urandom));
    end
    verify_regs("R1");

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule